// File: doc/BRIEF.md
# Cyclic Code Phase Sequencer

This block drives a feedback shift register that computes cyclic codes. Software writes one packed 24-bit count word. That word sets how many serial data bits are fed in, how many free-running feedback shifts follow, and how many result words are produced. The sequencer then moves through an input phase, a run phase and an output phase with no further help. At the end it returns to idle and pulses a completion flag.

One data FIFO is shared by the host and the engine. Before a job, the host loads input words into it. During the input phase the engine takes those words bit by bit, least significant bit first. During the output phase it assembles result words, least significant bit first, and writes them back into the same FIFO for the host to pop. A mode bit skips the input phase, so a job can continue from the shift register's present contents. A synchronous clear input empties the FIFO and stops any job in progress. The polynomial comes from a parameter, and the register is a plain tap-parity type.

Top module: `cc_phase_seq`

## Requirements
- R1: The count word has this layout: bits 7:0 are the input bit count, bits 15:8 are the run shift count, bits 22:16 are the output word count, and bit 23 is the mode bit. A write while idle starts a job, and `busy` is high from the next cycle.
- R2: A count-word write while `busy` is high has no effect on the job in progress: its length, shift register result and output words do not change.
- R3: With mode 0, the input phase lasts min(input count, 120) cycles and shifts one data bit per cycle. The bits are taken LSB first from successive FIFO words. A word is popped after its last bit is used, or at the end of the phase. A bit taken from an empty FIFO is 0. An input count of 0 skips the phase.
- R4: The run phase shifts the register once per cycle with zero data, for run-count cycles. A run count of 0 gives one cycle with no shift, and the output phase follows.
- R5: The output phase takes WORD_W cycles per word, for output-count words. Bit k of each word is the register MSB before the k-th shift of that word. Each word is pushed into the FIFO. An output count of 0 gives one cycle with no shift.
- R6: `phase` encodes 0 = idle, 1 = input, 2 = run, 3 = output. Phases advance only in that order. `shift_en` is high only while busy, and the total number of shift cycles is input + run + output_words*WORD_W.
- R7: A start with mode 1 ignores the input count, goes straight to the run phase, and keeps the register contents. A start with mode 0 clears the register to zero.
- R8: `done` is high for exactly one cycle: the first idle cycle after the output phase.
- R9: Each shift makes the register {s[W-2:0], parity(s & TAPS) ^ d}, where d is the data bit.
- R10: The FIFO is first-word-fall-through and holds FIFO_DEPTH words, with `fifo_level`, `fifo_full` and `fifo_empty` flags. Pushes are dropped when the FIFO is full. Host pushes are ignored while busy. Host pops are ignored during the input phase.
- R11: `clr` empties the FIFO and returns the sequencer to idle by the next cycle.
- R12: After reset the block is idle, the FIFO is empty and the register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of FIFO and sequencer |
| cfg_we | input | 1 | Count-word write strobe |
| cfg_wdata | input | 24 | Count word |
| host_push | input | 1 | Host FIFO push |
| host_wdata | input | WORD_W | Host push data |
| host_pop | input | 1 | Host FIFO pop |
| host_rdata | output | WORD_W | FIFO head word |
| fifo_level | output | $clog2(FIFO_DEPTH)+1 | Words in FIFO |
| fifo_empty | output | 1 | FIFO empty |
| fifo_full | output | 1 | FIFO full |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job-finished pulse |
| phase | output | 2 | Current phase code |
| shift_en | output | 1 | Shift register clock enable |
| lfsr_q | output | WORD_W | Shift register contents |

## Verification
The hardest cases to reach are the phase boundaries. These include an input count that ends partway through a FIFO word, run or output counts of zero that leave a single non-shifting cycle, and an input count above the 120-bit limit. The bench reaches them with a sweep over input, run and output counts that contains those values, and it models the register bit by bit for every combination. A mode-1 job that starts with a word left in the FIFO shows that the input phase was skipped. Writes and host pushes placed in the middle of a job, an output count larger than the FIFO, and a mid-job clear cover the remaining edge conditions.

// File: rtl/ccps_pkg.sv
// Package: shared types and field sizes for the cyclic code phase sequencer.
// Assumes the count word layout is fixed (neighbours decode it by position).
package ccps_pkg;

    localparam int CNT_WORD_W = 24;
    localparam int IN_CNT_W   = 8;
    localparam int RUN_CNT_W  = 8;
    localparam int OUT_CNT_W  = 7;
    localparam int IN_CNT_MAX = 120;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_IN   = 2'd1,
        PH_RUN  = 2'd2,
        PH_OUT  = 2'd3
    } phase_t;

    // Packed count word, MSB first: mode, output words, run shifts, input bits.
    typedef struct packed {
        logic                 mode;
        logic [OUT_CNT_W-1:0] out_words;
        logic [RUN_CNT_W-1:0] run_len;
        logic [IN_CNT_W-1:0]  in_bits;
    } cnt_word_t;

    // Clamp the input bit count to the allowed maximum.
    function automatic logic [IN_CNT_W-1:0] clamp_in(input logic [IN_CNT_W-1:0] v);
        return (v > IN_CNT_W'(IN_CNT_MAX)) ? IN_CNT_W'(IN_CNT_MAX) : v;
    endfunction

endpackage

// File: rtl/ccps_fifo.sv
// Module: first-word-fall-through data FIFO shared by host and engine.
// Assumes DEPTH is a power of two. Push to full and pop from empty are dropped.
module ccps_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic [LW-1:0] level,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [LW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr_q];
    assign level   = cnt_q;

    // Storage write; the contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr_q] <= wdata;
        end
    end

    // Pointer and occupancy tracking with hardware reset and synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/ccps_lfsr.sv
// Module: tap-parity feedback shift register used as the coding engine.
// Each enabled cycle shifts left; the new LSB is parity(state & TAPS) xor din.
module ccps_lfsr #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   TAPS = 'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         zero,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] state,
    output logic         msb
);

    logic [W-1:0] st_q;
    logic         fb;

    assign fb    = (^(st_q & TAPS)) ^ din;
    assign state = st_q;
    assign msb   = st_q[W-1];

    // Register update: clear on request, otherwise shift when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || zero) begin
            st_q <= '0;
        end else if (shift) begin
            st_q <= {st_q[W-2:0], fb};
        end
    end

endmodule

// File: rtl/ccps_seq.sv
// Module: phase sequencer. It decodes the count word and steps through the
// input, run and output phases. It assumes a FWFT FIFO head and that the
// register MSB is the serial output.
module ccps_seq
    import ccps_pkg::*;
#(
    parameter int W  = 8,
    localparam int BW = (W > 1) ? $clog2(W) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         cfg_we,
    input  cnt_word_t    cfg,
    input  logic [W-1:0] head_word,
    input  logic         head_empty,
    input  logic         reg_msb,
    output logic         shift,
    output logic         sdata,
    output logic         reg_zero,
    output logic         seq_pop,
    output logic         seq_push,
    output logic [W-1:0] push_word,
    output logic         busy,
    output logic         done,
    output phase_t       phase
);

    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    phase_t               ph_q;
    logic [IN_CNT_W-1:0]  cnt_q;
    logic [RUN_CNT_W-1:0] run_q;
    logic [OUT_CNT_W-1:0] outw_q, words_q;
    logic [BW-1:0]        bidx_q;
    logic [W-1:0]         acc_q;
    logic                 done_q;
    logic [IN_CNT_W-1:0]  in_eff;

    assign in_eff = clamp_in(cfg.in_bits);
    assign phase  = ph_q;
    assign busy   = (ph_q != PH_IDLE);
    assign done   = done_q;

    // Datapath strobes derived from the current phase and its counters.
    always_comb begin
        shift     = 1'b0;
        sdata     = 1'b0;
        seq_pop   = 1'b0;
        seq_push  = 1'b0;
        reg_zero  = 1'b0;
        push_word = {reg_msb, acc_q[W-2:0]};
        if (!clr) begin
            case (ph_q)
                PH_IDLE: reg_zero = cfg_we && !cfg.mode;
                PH_IN: begin
                    shift   = 1'b1;
                    sdata   = !head_empty && head_word[bidx_q];
                    seq_pop = (bidx_q == LAST_BIT) || (cnt_q == IN_CNT_W'(1));
                end
                PH_RUN:  shift = (cnt_q != '0);
                PH_OUT: begin
                    shift    = (words_q != '0);
                    seq_push = (words_q != '0) && (bidx_q == LAST_BIT);
                end
                default: shift = 1'b0;
            endcase
        end
    end

    // Phase state machine and its counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ph_q    <= PH_IDLE;
            cnt_q   <= '0;
            run_q   <= '0;
            outw_q  <= '0;
            words_q <= '0;
            bidx_q  <= '0;
            acc_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (cfg_we) begin
                        run_q  <= cfg.run_len;
                        outw_q <= cfg.out_words;
                        bidx_q <= '0;
                        if (!cfg.mode && in_eff != '0) begin
                            ph_q  <= PH_IN;
                            cnt_q <= in_eff;
                        end else begin
                            ph_q  <= PH_RUN;
                            cnt_q <= cfg.run_len;
                        end
                    end
                end
                PH_IN: begin
                    cnt_q  <= cnt_q - 1'b1;
                    bidx_q <= seq_pop ? '0 : bidx_q + 1'b1;
                    if (cnt_q == IN_CNT_W'(1)) begin
                        ph_q  <= PH_RUN;
                        cnt_q <= run_q;
                    end
                end
                PH_RUN: begin
                    if (cnt_q <= RUN_CNT_W'(1)) begin
                        ph_q    <= PH_OUT;
                        words_q <= outw_q;
                        bidx_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_OUT: begin
                    if (words_q == '0) begin
                        ph_q   <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        acc_q[bidx_q] <= reg_msb;
                        if (bidx_q == LAST_BIT) begin
                            bidx_q  <= '0;
                            words_q <= words_q - 1'b1;
                            if (words_q == OUT_CNT_W'(1)) begin
                                ph_q   <= PH_IDLE;
                                done_q <= 1'b1;
                            end
                        end else begin
                            bidx_q <= bidx_q + 1'b1;
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cc_phase_seq.sv
// Module: top level of the cyclic code phase sequencer. It joins the
// count-word port, the shared FIFO, the shift register and the sequencer.
// The engine owns the FIFO write side while busy and the read side
// during the input phase.
module cc_phase_seq
    import ccps_pkg::*;
#(
    parameter int                WORD_W     = 8,
    parameter int                FIFO_DEPTH = 16,
    parameter logic [WORD_W-1:0] TAPS       = 'hB8,
    localparam int               LVL_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cfg_we,
    input  logic [23:0]       cfg_wdata,
    input  logic              host_push,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_pop,
    output logic [WORD_W-1:0] host_rdata,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              busy,
    output logic              done,
    output logic [1:0]        phase,
    output logic              shift_en,
    output logic [WORD_W-1:0] lfsr_q
);

    cnt_word_t         cfg_w;
    phase_t            ph;
    logic              sdata, reg_zero, reg_msb;
    logic              seq_pop, seq_push;
    logic [WORD_W-1:0] push_word;
    logic              f_push, f_pop;
    logic [WORD_W-1:0] f_wdata;

    assign cfg_w = cnt_word_t'(cfg_wdata);
    assign phase = ph;

    // FIFO port arbitration: the engine has priority and host access is gated by phase.
    always_comb begin
        f_push  = seq_push || (host_push && !busy);
        f_wdata = seq_push ? push_word : host_wdata;
        f_pop   = seq_pop || (host_pop && ph != PH_IN);
    end

    ccps_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .rdata (host_rdata),
        .level (fifo_level),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    ccps_lfsr #(.W(WORD_W), .TAPS(TAPS)) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .zero  (reg_zero),
        .shift (shift_en),
        .din   (sdata),
        .state (lfsr_q),
        .msb   (reg_msb)
    );

    ccps_seq #(.W(WORD_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .cfg_we     (cfg_we),
        .cfg        (cfg_w),
        .head_word  (host_rdata),
        .head_empty (fifo_empty),
        .reg_msb    (reg_msb),
        .shift      (shift_en),
        .sdata      (sdata),
        .reg_zero   (reg_zero),
        .seq_pop    (seq_pop),
        .seq_push   (seq_push),
        .push_word  (push_word),
        .busy       (busy),
        .done       (done),
        .phase      (ph)
    );

endmodule

// File: rtl/ccps_chk.sv
// Module: protocol checker for cc_phase_seq, attached by bind. It watches only
// the top-level ports.
module ccps_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             cfg_we,
    input logic             busy,
    input logic             done,
    input logic [1:0]       phase,
    input logic             shift_en,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_empty,
    input logic             fifo_full
);

    // Shifting happens only inside a job.
    assert_shift_in_job_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> busy);

    // The input phase is followed only by itself or by the run phase.
    assert_in_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && !clr) |=> (phase == 2'd1 || phase == 2'd2));

    // The run phase is followed only by itself or by the output phase.
    assert_run_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && !clr) |=> (phase == 2'd2 || phase == 2'd3));

    // The output phase is followed only by itself or by idle.
    assert_out_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3 && !clr) |=> (phase == 2'd3 || phase == 2'd0));

    // An idle write starts a job.
    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we && !clr) |=> busy);

    // done appears while idle, only right after the output phase, for one cycle.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(phase) == 2'd3));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // clr empties the FIFO and stops the job.
    assert_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!busy && fifo_empty && fifo_level == '0));

    // FIFO flags agree with occupancy, which stays within capacity.
    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));
    assert_full_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> (fifo_level == LVL_W'(DEPTH)));
    assert_empty_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> (fifo_level == '0));

endmodule

bind cc_phase_seq ccps_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .cfg_we     (cfg_we),
    .busy       (busy),
    .done       (done),
    .phase      (phase),
    .shift_en   (shift_en),
    .fifo_level (fifo_level),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full)
);

// File: tb/cc_phase_seq_tb_top.sv
// Bench: sweeps count-word values and checks each job against an arithmetic
// model of the shift register, FIFO and phase timing.
module cc_phase_seq_tb_top;

    localparam int         W     = 8;
    localparam int         DEPTH = 16;
    localparam logic [7:0] TAPS  = 8'hB8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        host_push = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        host_pop = 1'b0;
    logic [7:0]  host_rdata;
    logic [4:0]  fifo_level;
    logic        fifo_empty, fifo_full, busy, done, shift_en;
    logic [1:0]  phase;
    logic [7:0]  lfsr_q;

    int total = 0;
    int bad   = 0;
    logic [7:0] m_state = '0;

    always #10 clk = ~clk;

    cc_phase_seq #(.WORD_W(W), .FIFO_DEPTH(DEPTH), .TAPS(TAPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
        .host_rdata(host_rdata), .fifo_level(fifo_level), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .busy(busy), .done(done), .phase(phase),
        .shift_en(shift_en), .lfsr_q(lfsr_q)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] step(input logic [7:0] s, input logic d);
        return {s[6:0], (^(s & TAPS)) ^ d};
    endfunction

    function automatic logic [7:0] gen_word(input int seed, input int k);
        return 8'((seed * 37 + k * 91 + 5) & 255);
    endfunction

    task automatic host_put(input logic [7:0] d);
        host_push = 1'b1;
        host_wdata = d;
        @(negedge clk);
        host_push = 1'b0;
    endtask

    // Runs one job; poke > 0 injects a write and a host push at that busy cycle.
    task automatic run_job(input int ic, input int rc, input int oc, input bit cm,
                           input int np, input int seed, input int poke);
        logic [7:0] pushed [16];
        logic [7:0] expq [40];
        int ie, consumed, nexp, n, sh, nkeep, b;
        logic [7:0] s, wd;
        for (int k = 0; k < np; k++) begin
            pushed[k] = gen_word(seed, k);
            host_put(pushed[k]);
        end
        // Model of the job.
        ie = cm ? 0 : ((ic > 120) ? 120 : ic);
        s  = cm ? m_state : 8'h00;
        for (int j = 0; j < ie; j++) begin
            b = ((j / W) < np) ? int'(pushed[j / W][j % W]) : 0;
            s = step(s, b[0]);
        end
        for (int j = 0; j < rc; j++) s = step(s, 1'b0);
        consumed = ((ie + W - 1) / W < np) ? (ie + W - 1) / W : np;
        nexp = 0;
        for (int k = consumed; k < np; k++) begin
            expq[nexp] = pushed[k];
            nexp++;
        end
        for (int w = 0; w < oc; w++) begin
            wd = '0;
            for (int k = 0; k < W; k++) begin
                wd[k] = s[7];
                s = step(s, 1'b0);
            end
            expq[nexp] = wd;
            nexp++;
        end
        m_state = s;
        nkeep = (nexp > DEPTH) ? DEPTH : nexp;
        // Start the job.
        cfg_wdata = {cm, 7'(oc), 8'(rc), 8'(ic)};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R1", "busy after write", int'(busy), 1);
        check("R6", "first phase", int'(phase), (ie > 0) ? 1 : 2);
        n = 0;
        sh = 0;
        while (busy && n < 5000) begin
            n++;
            sh += int'(shift_en);
            if (n == poke) begin
                cfg_wdata = 24'h7FFF11;
                cfg_we = 1'b1;
                host_push = 1'b1;
                host_wdata = 8'hAA;
            end
            @(negedge clk);
            cfg_we = 1'b0;
            host_push = 1'b0;
        end
        check((poke > 0) ? "R2" : "R3", "busy cycles", n,
              ie + ((rc > 0) ? rc : 1) + ((oc > 0) ? oc * W : 1));
        check("R6", "shift cycles", sh, ie + rc + oc * W);
        check("R8", "done at first idle", int'(done), 1);
        check(cm ? "R7" : "R9", "register result", int'(lfsr_q), int'(m_state));
        check("R10", "fifo level", int'(fifo_level), nkeep);
        for (int k = 0; k < nkeep; k++) begin
            check("R5", "fifo word", int'(host_rdata), int'(expq[k]));
            host_pop = 1'b1;
            @(negedge clk);
            host_pop = 1'b0;
        end
        check("R10", "fifo drained", int'(fifo_empty), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int icl [9] = '{0, 1, 7, 8, 9, 16, 33, 120, 200};
        int rcl [3] = '{0, 1, 5};
        int ocl [3] = '{0, 1, 3};
        int seed;
        int iee;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: state after reset.
        check("R12", "busy", int'(busy), 0);
        check("R12", "fifo empty", int'(fifo_empty), 1);
        check("R12", "register", int'(lfsr_q), 0);
        check("R12", "phase", int'(phase), 0);
        check("R12", "done", int'(done), 0);

        // R3 R4 R5: sweep of counts, each input supplied with just enough words.
        seed = 1;
        foreach (icl[a]) foreach (rcl[r]) foreach (ocl[o]) begin
            iee = (icl[a] > 120) ? 120 : icl[a];
            run_job(icl[a], rcl[r], ocl[o], 1'b0, (iee + W - 1) / W, seed, 0);
            seed++;
        end

        // R7: mode 1 keeps the register and leaves a queued word untouched.
        run_job(20, 3, 2, 1'b0, 3, 50, 0);
        run_job(50, 4, 2, 1'b1, 1, 51, 0);
        run_job(0, 0, 1, 1'b1, 0, 52, 0);

        // R3: input runs past the loaded words and reads zeros.
        run_job(20, 2, 1, 1'b0, 1, 60, 0);

        // R2: a write and a host push in the middle of a job are ignored.
        run_job(20, 10, 2, 1'b0, 3, 70, 3);
        run_job(9, 10, 2, 1'b0, 2, 71, 15);

        // R10: more output words than the FIFO holds.
        run_job(8, 2, 20, 1'b0, 1, 80, 0);

        // R11: clear in the middle of a job with words still queued.
        for (int k = 0; k < 5; k++) host_put(gen_word(90, k));
        cfg_wdata = {1'b0, 7'd2, 8'd5, 8'd40};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (10) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R11", "busy after clear", int'(busy), 0);
        check("R11", "fifo empty after clear", int'(fifo_empty), 1);
        check("R11", "level after clear", int'(fifo_level), 0);
        check("R11", "phase after clear", int'(phase), 0);

        // After the clear, a fresh job runs normally.
        run_job(12, 1, 2, 1'b0, 2, 91, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule